// File: doc/BRIEF.md
# Interrupt Mask-Acknowledge Status Port

This block is one 8-bit I/O register that gathers three interrupt sources for a small handheld computer. The sources are a push-button key input and two periodic timers that never stop. The block presents one level-sensitive interrupt request to the CPU, which stays high while any source is pending.

A single CPU write does two jobs at once, bit by bit. A 1 in a source bit enables that source. A 0 in a source bit disables the source and drops its pending line. Acknowledging a source and then re-enabling it therefore takes two writes: first a value with the serviced bit at 0, then a value with it back at 1. If the CPU writes the enable back without clearing first, a line that is still pending keeps the request high, and the CPU takes the interrupt again straight away.

A read returns the pending sources while any are pending. While none is pending, the read returns the synchronized key level in bit 3. Bit 3 of a write is not a source bit: it is kept as a display-power flag output.

Each source is tracked by its own three-state machine:
- `SRC_OFF`: disabled, nothing pending.
- `SRC_ARMED`: enabled, waiting for an event.
- `SRC_FIRED`: enabled and pending.

The transitions are:
- Enable: `SRC_OFF`→`SRC_ARMED` on a write with the bit at 1.
- Enable-and-hit: `SRC_OFF`→`SRC_FIRED` on that write when an event occurs in the same cycle.
- Hit: `SRC_ARMED`→`SRC_FIRED` on an event when no write clears the bit.
- Disarm: `SRC_ARMED`→`SRC_OFF` on a write with the bit at 0.
- Acknowledge: `SRC_FIRED`→`SRC_OFF` on a write with the bit at 0.

Every other condition holds the current state. In particular, a write of 1 in `SRC_FIRED` keeps the source pending.

Top module: `irq_port`

## Requirements
- R1: During and after reset, before any write, every source is disabled and not pending. `irq` is 0, `disp_on` is 0, and `rd_data` is 0x00 while the key is released.
- R2: Source bits are: bit 0 for the key, bit 1 for timer 1, bit 2 for timer 2. A write with a source bit at 1 enables that source, and an event of an enabled source sets its pending bit. Writing 0x0B enables the key and timer 1 but not timer 2. Writing 0x0F enables all three.
- R3: A write with a source bit at 0 clears that source's pending bit on the write edge. Later events of that source are ignored until a write sets the bit to 1 again.
- R4: A write with a source bit at 1 does not clear a pending bit of that source. Rewriting 0x0B while timer 1 is pending leaves `irq` at 1 and `rd_data` at 0x02.
- R5: Timer k raises an event once every `TK_CYCLES` clock cycles. Its events fall on the edges where the number of edges since reset release, counted from 0, modulo `TK_CYCLES`, equals `TK_CYCLES-1`. Writes and masking never move this phase.
- R6: `irq` is the OR of the three pending bits. A pending bit stays set with no further event until a write acknowledges it.
- R7: While any source is pending, `rd_data` is {5'b0, pending[2:0]}. While none is pending, `rd_data` is 0x08 if the synchronized key is high and 0x00 if it is low. Bits 7..4 always read 0.
- R8: The key input passes through a two-flop synchronizer. Its level shows in `rd_data` bit 3 after two clock edges. A key event is a rising edge of the synchronized level, and it sets the key pending bit on the third edge after the input rises.
- R9: `disp_on` takes bit 3 of every write on the write edge, and holds its value while no write occurs.
- R10: If a source event and a write to the port fall in the same cycle, the source ends up pending only if the written bit for that source is 1.
- R11: With the key and timer 1 both pending, writing 0x09 clears timer 1 and keeps the key pending (`rd_data` = 0x01). Writing 0x0A then clears the key, so `rd_data` reads 0x08 with the key held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle CPU write strobe |
| wr_data | input | 8 | Written value: enables and acknowledges in bits 2..0, display flag in bit 3 |
| rd_data | output | 8 | Pending sources, or the key level when nothing is pending |
| key_in | input | 1 | Asynchronous push-button level |
| irq | output | 1 | Level interrupt request to the CPU |
| disp_on | output | 1 | Stored display-power flag |

## Verification
The main function is tried with four kinds of input pattern:
- Plain enable writes followed by long idle stretches show that the timers have a fixed period and that the request is held as a level.
- Re-enable writes without a prior clear, set against zero-bit writes, tell "enable only" apart from "acknowledge and disable".
- Mixed writes with both the key and a timer pending show that each bit is acknowledged on its own.
- Writes placed exactly on a timer's event cycle, once with the bit at 1 and once at 0, settle which side wins a same-cycle collision.

A reference model built from the requirements is compared against the design over long stretches with all sources enabled. This shows whether the timer phase survives repeated masking.

// File: rtl/irq_port_pkg.sv
package irq_port_pkg;
    localparam int DATA_W    = 8;
    localparam int NUM_SRC   = 3;
    localparam int NUM_TMR   = 2;
    localparam int SRC_KEY   = 0;
    localparam int SRC_TMR0  = 1;
    localparam int BIT_LEVEL = 3;

    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_ARMED = 2'd1,
        SRC_FIRED = 2'd2
    } src_state_e;
endpackage

// File: rtl/irq_key_sync.sv
module irq_key_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b0;
                else if (g == 0) chain[g] <= key_in;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= 1'b0;
        else last <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~last;
endmodule

// File: rtl/irq_period_timer.sv
module irq_period_timer #(
    parameter int PERIOD = 96
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/irq_src_fsm.sv
module irq_src_fsm
    import irq_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic event_in,
    output logic pending
);
    src_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SRC_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SRC_OFF: begin
                if (wr_en && wr_bit) nxt = event_in ? SRC_FIRED : SRC_ARMED;
            end
            SRC_ARMED: begin
                if (wr_en && !wr_bit) nxt = SRC_OFF;
                else if (event_in)    nxt = SRC_FIRED;
            end
            SRC_FIRED: begin
                if (wr_en && !wr_bit) nxt = SRC_OFF;
            end
            default: nxt = SRC_OFF;
        endcase
    end

    always_comb begin
        pending = (state == SRC_FIRED);
    end
endmodule

// File: rtl/irq_port.sv
module irq_port
    import irq_port_pkg::*;
#(
    parameter int T1_CYCLES   = 96,
    parameter int T2_CYCLES   = 160,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              key_in,
    output logic              irq,
    output logic              disp_on
);
    logic [NUM_SRC-1:0] src_event;
    logic [NUM_SRC-1:0] pend;
    logic               key_level;
    logic               key_rise;
    logic               unused_wr_hi;

    assign unused_wr_hi = ^wr_data[DATA_W-1:BIT_LEVEL+1];

    irq_key_sync #(.STAGES(SYNC_STAGES)) u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .key_in(key_in),
        .level (key_level),
        .rise  (key_rise)
    );
    assign src_event[SRC_KEY] = key_rise;

    genvar t;
    generate
        for (t = 0; t < NUM_TMR; t++) begin : g_tmr
            localparam int P = (t == 0) ? T1_CYCLES : T2_CYCLES;
            irq_period_timer #(.PERIOD(P)) u_tmr (
                .clk  (clk),
                .rst_n(rst_n),
                .tick (src_event[SRC_TMR0+t])
            );
        end
    endgenerate

    genvar s;
    generate
        for (s = 0; s < NUM_SRC; s++) begin : g_src
            irq_src_fsm u_fsm (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (wr_en),
                .wr_bit  (wr_data[s]),
                .event_in(src_event[s]),
                .pending (pend[s])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     disp_on <= 1'b0;
        else if (wr_en) disp_on <= wr_data[BIT_LEVEL];
    end

    always_comb begin
        rd_data = '0;
        if (|pend) rd_data[NUM_SRC-1:0] = pend;
        else       rd_data[BIT_LEVEL]   = key_level;
    end

    assign irq = |pend;
endmodule

// File: rtl/irq_port_chk.sv
module irq_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       irq,
    input logic       disp_on
);
    p_pending_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_data[7:3] == 5'd0 && rd_data[2:0] != 3'd0));

    p_idle_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (rd_data[2:0] == 3'd0 && rd_data[7:4] == 4'd0));

    p_zero_clears_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[0]) |=> !rd_data[0]);

    p_zero_clears_t1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[1]) |=> !rd_data[1]);

    p_zero_clears_t2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[2]) |=> !rd_data[2]);

    p_one_keeps_t1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[1] && irq && rd_data[1]) |=> (irq && rd_data[1]));

    p_level_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && irq) |=> irq);

    p_disp_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (disp_on == $past(wr_data[3])));

    p_disp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(disp_on));
endmodule

bind irq_port irq_port_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .irq    (irq),
    .disp_on(disp_on)
);

// File: tb/sim_irq_port.sv
`timescale 1ns/1ps
module sim_irq_port;
    localparam int P1 = 96;
    localparam int P2 = 160;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       key_in = 1'b0;
    logic [7:0] rd_data;
    logic       irq;
    logic       disp_on;

    always #2.5 clk = ~clk;

    irq_port #(.T1_CYCLES(P1), .T2_CYCLES(P2), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .key_in(key_in), .irq(irq), .disp_on(disp_on)
    );

    // reference model built from the requirements
    logic [2:0] m_en, m_pend, m_ev;
    logic       mk1, mk2, mk3, m_disp;
    int         m_cyc;

    always_comb begin
        m_ev[0] = mk2 & ~mk3;                // R8
        m_ev[1] = ((m_cyc % P1) == P1 - 1);  // R5
        m_ev[2] = ((m_cyc % P2) == P2 - 1);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en <= '0; m_pend <= '0; mk1 <= 0; mk2 <= 0; mk3 <= 0;
            m_disp <= 0; m_cyc <= 0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                logic nen;
                nen = wr_en ? wr_data[i] : m_en[i];
                if (wr_en && !wr_data[i])   m_pend[i] <= 1'b0;
                else if (m_ev[i] && nen)    m_pend[i] <= 1'b1;
                m_en[i] <= nen;
            end
            if (wr_en) m_disp <= wr_data[3];
            mk1 <= key_in; mk2 <= mk1; mk3 <= mk2;
            m_cyc <= m_cyc + 1;
        end
    end

    function automatic logic [7:0] m_rd();
        return (m_pend != 0) ? {5'b0, m_pend} : {4'b0, mk2, 3'b0};
    endfunction

    typedef struct {
        logic [7:0] rd;
        logic       irq;
        logic       disp;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    task automatic push(string tag, logic [7:0] rd, logic ir, logic dp);
        exp_t e;
        e.rd = rd; e.irq = ir; e.disp = dp; e.tag = tag;
        q.push_back(e);
        #0.5;
    endtask

    task automatic push_model(string tag);
        push(tag, m_rd(), |m_pend, m_disp);
    endtask

    initial begin : monitor
        forever begin
            exp_t e;
            wait (q.size() != 0);
            e = q.pop_front();
            n_chk++;
            if (rd_data !== e.rd || irq !== e.irq || disp_on !== e.disp) begin
                n_fail++;
                $display("FAIL %s: rd=%02h irq=%0b disp=%0b expected rd=%02h irq=%0b disp=%0b",
                         e.tag, rd_data, irq, disp_on, e.rd, e.irq, e.disp);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin : driver
        step(3);
        push("R1 in reset", 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        step(2);
        push("R1 after reset", 8'h00, 1'b0, 1'b0);

        wr(8'h0B);                                   // R2 enable key + timer1
        step(110);
        push("R2 R5 R6 timer1 pending held", 8'h02, 1'b1, 1'b1);

        wr(8'h0B);                                   // R4 rewrite without clear
        push("R4 re-enable keeps pending", 8'h02, 1'b1, 1'b1);

        key_in = 1'b1;                               // R8
        step(2);
        push("R8 level at two edges, no event yet", 8'h02, 1'b1, 1'b1);
        step(1);
        push("R8 key pending on third edge", 8'h03, 1'b1, 1'b1);

        wr(8'h09);                                   // R11
        push("R11 0x09 clears timers keeps key", 8'h01, 1'b1, 1'b1);
        wr(8'h0A);
        push("R11 R7 0x0A clears key, idle read", 8'h08, 1'b0, 1'b1);

        key_in = 1'b0; step(4);                      // R3 key disabled
        key_in = 1'b1; step(5);
        push("R3 disabled key ignored", 8'h08, 1'b0, 1'b1);

        wr(8'h0F);                                   // R2 R5 all enabled, phase
        for (int c = 0; c < 400; c++) begin
            push_model("R5 R2 free-running phase");
            step(1);
            if (c % 50 == 25) wr(8'h0F);
        end

        wr(8'h08);
        push("R3 0x08 clears all", 8'h08, 1'b0, 1'b1);

        // R10 event on the write cycle with bit at 1
        while ((m_cyc % P1) != P1 - 1) step(1);
        wr(8'h0A);
        push("R10 same-cycle write 1 lets event in", 8'h02, 1'b1, 1'b1);
        wr(8'h08);
        wr(8'h0F);
        while ((m_cyc % P1) != P1 - 1) step(1);
        wr(8'h0D);
        push_model("R10 same-cycle write 0 blocks event");
        if (rd_data[1] !== 1'b0) begin
            n_fail++;
            $display("FAIL R10: rd bit1=%0b expected 0", rd_data[1]);
        end
        n_chk++;

        wr(8'h04);                                   // R9
        push_model("R9 display flag cleared by bit 3");
        step(200);
        push_model("R9 R5 timer2 alone");

        key_in = 1'b0;
        wr(8'h00);
        step(3);
        push("R7 idle read with key released", 8'h00, 1'b0, 1'b0);

        wait (q.size() == 0);
        #1;
        done = 1;
        summary();
        $finish;
    end
endmodule